// File: doc/BRIEF.md
# Serial Conversion Result Output Register

This block is the digital output stage of a 12-bit data converter's serial port. It keeps the most recent conversion result in an output register and presents it one bit at a time on a serial data pin. An external host supplies the serial clock and an active-low select. The analog conversion is outside the block. A completion strobe carries each new result word into the block, and a start strobe marks the beginning of the next conversion.

A new word is taken in only when a conversion finishes, which is the moment the `ready` output rises. The word is accepted only if the serial clock is low or the select is inactive at that moment. If the host is mid-clock with the part selected, the old contents stay in place and a one-cycle lost-result pulse is raised. A stored result therefore stays readable while the next conversion runs. Bits change on falling serial-clock edges so that the host can capture them on rising edges. After the least significant bit has been captured, the pin is held low.

The serial clock and the select are asynchronous to the system clock. Each passes through a two-stage synchronizer, and all edge decisions use the synchronized copies.

Top module: `adc_result_shifter`

## Requirements
- R1: After reset, `ready` and `result_lost` are 0, `ser_data` is 0, and the stored word is all zeros, so a full read with the select active returns twelve 0 bits.
- R2: While selected, `ser_data` first shows bit 11 of the stored word. Each falling `ser_clk` edge advances the output by one position, down to bit 0, so the word leaves most significant bit first.
- R3: On a `conv_done` cycle, the word is stored if the synchronized `ser_clk` is 0 or the synchronized `sel_n` is 1. A stored word resets the bit position, so bit 11 of the new word appears at once if the block is selected.
- R4: On a `conv_done` cycle with the synchronized `ser_clk` at 1 and `sel_n` at 0, the word is discarded. The old contents and the read position are kept, and `result_lost` is 1 for exactly the next cycle.
- R5: After the twelfth falling `ser_clk` edge, bit 0 stays on `ser_data` until the next rising edge. From that thirteenth rising edge on, `ser_data` is 0 for any further clocks until the select is released or a new word is stored.
- R6: While `sel_n` is 1, `ser_data` is 0 and the read position is held at the start. A later select fall therefore shows bit 11 of the stored word again.
- R7: `ready` rises in the cycle after `conv_done`. It falls in the cycle after `conv_start` when `conv_done` is absent, and `conv_done` wins if both strobes arrive together.
- R8: While a conversion is running (`ready` 0), the stored word can be read normally.
- R9: A fall of `sel_n` shows on `ser_data` after the second system clock edge and not after the first.
- R10: A word stored in the middle of a read restarts the output at bit 11 of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_done | input | 1 | One-cycle strobe: a conversion ends, `conv_word` is valid |
| conv_word | input | RES_W | Result of the finished conversion |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| sel_n | input | 1 | Host select, active low, asynchronous |
| ser_data | output | 1 | Serial result bit |
| ready | output | 1 | High from the end of a conversion until the next start |
| result_lost | output | 1 | One-cycle pulse when a finished result was discarded |

## Verification
A wrong bit index or state in the shift sequencer appears on `ser_data` at the next sampled half-period. This happens either as a bit out of order or as a pin that goes low one clock early or late. A wrongly gated load shows in the next read as an old word where a new one was expected, or the reverse. It also shows one cycle after the strobe as a missing or extra `result_lost` pulse. Synchronizer depth errors shift the select response by one system clock, and the bench checks that edge exactly.

// File: rtl/adcsr_pkg.sv
package adcsr_pkg;

    // Readout phase of the serial sequencer.
    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,  // deselected, position parked at the top bit
        SEQ_SHIFT = 2'd1,  // bits being walked out on falling edges
        SEQ_TAIL  = 2'd2,  // last bit on the pin, awaiting its capture edge
        SEQ_SPENT = 2'd3   // all bits taken, pin forced low
    } seq_state_t;

    // Synchronized pin with its edge events.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    // Width of a bit index for a word of the given width.
    function automatic int idx_width(input int word_w);
        return (word_w > 1) ? $clog2(word_w) : 1;
    endfunction

endpackage

// File: rtl/adcsr_sync.sv
module adcsr_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/adcsr_edge.sv
module adcsr_edge
    import adcsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    level_in,
    output pin_ev_t ev
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    always_comb begin
        ev.level = level_in;
        ev.rise  = level_in & ~prev_q;
        ev.fall  = ~level_in & prev_q;
    end

endmodule

// File: rtl/adcsr_load_gate.sv
module adcsr_load_gate #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_word,
    input  logic             sclk_level,
    input  logic             selected,
    output logic             load_ok,
    output logic [RES_W-1:0] hold_word,
    output logic             ready,
    output logic             lost
);

    logic             accept;
    logic [RES_W-1:0] hold_q;
    logic             ready_q;
    logic             lost_q;

    // A finished word may enter only while the host is not mid-clock.
    always_comb begin
        accept  = ~sclk_level | ~selected;
        load_ok = conv_done & accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
            lost_q  <= 1'b0;
        end else begin
            if (load_ok) hold_q <= conv_word;
            lost_q <= conv_done & ~accept;
            if (conv_done)       ready_q <= 1'b1;
            else if (conv_start) ready_q <= 1'b0;
        end
    end

    assign hold_word = hold_q;
    assign ready     = ready_q;
    assign lost      = lost_q;

endmodule

// File: rtl/adcsr_bit_seq.sv
module adcsr_bit_seq
    import adcsr_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             selected,
    input  logic             load_ok,
    input  pin_ev_t          sclk_ev,
    input  logic [RES_W-1:0] hold_word,
    output logic             bit_out
);

    localparam int IDX_W = idx_width(RES_W);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(RES_W - 1);

    seq_state_t       st_q;
    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] sel_bit;

    always_ff @(posedge clk) begin
        if (rst || !selected) begin
            st_q  <= SEQ_OFF;
            pos_q <= '0;
        end else if (load_ok) begin
            st_q  <= SEQ_SHIFT;
            pos_q <= '0;
        end else begin
            unique case (st_q)
                SEQ_OFF, SEQ_SHIFT: begin
                    st_q <= SEQ_SHIFT;
                    if (sclk_ev.fall) begin
                        if (pos_q == LAST_POS) st_q  <= SEQ_TAIL;
                        else                   pos_q <= pos_q + 1'b1;
                    end
                end
                SEQ_TAIL: begin
                    if (sclk_ev.rise) st_q <= SEQ_SPENT;
                end
                SEQ_SPENT: begin
                    st_q <= SEQ_SPENT;
                end
                default: begin
                    st_q <= SEQ_OFF;
                end
            endcase
        end
    end

    // Position counts from the top bit downwards.
    always_comb begin
        sel_bit = LAST_POS - pos_q;
        bit_out = selected && (st_q != SEQ_SPENT) ? hold_word[sel_bit] : 1'b0;
    end

endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
    import adcsr_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_word,
    input  logic             ser_clk,
    input  logic             sel_n,
    output logic             ser_data,
    output logic             ready,
    output logic             result_lost
);

    // Bit 1: serial clock, bit 0: select (reset to deselected).
    localparam int          PIN_W   = 2;
    localparam logic [1:0]  PIN_RST = 2'b01;

    logic [PIN_W-1:0] pins_s;
    pin_ev_t          sclk_ev;
    logic             selected;
    logic             load_ok;
    logic [RES_W-1:0] hold_word;

    adcsr_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_clk, sel_n}),
        .sync_out (pins_s)
    );

    assign selected = ~pins_s[0];

    adcsr_edge u_sclk_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (pins_s[1]),
        .ev       (sclk_ev)
    );

    adcsr_load_gate #(
        .RES_W (RES_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .conv_word  (conv_word),
        .sclk_level (sclk_ev.level),
        .selected   (selected),
        .load_ok    (load_ok),
        .hold_word  (hold_word),
        .ready      (ready),
        .lost       (result_lost)
    );

    adcsr_bit_seq #(
        .RES_W (RES_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .selected  (selected),
        .load_ok   (load_ok),
        .sclk_ev   (sclk_ev),
        .hold_word (hold_word),
        .bit_out   (ser_data)
    );

endmodule

// File: rtl/adcsr_checker.sv
module adcsr_checker (
    input logic clk,
    input logic rst,
    input logic conv_start,
    input logic conv_done,
    input logic sel_n,
    input logic ser_data,
    input logic ready,
    input logic result_lost
);

    p_lost_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        result_lost |-> $past(conv_done));

    p_lost_implies_ready_r4: assert property (@(posedge clk) disable iff (rst)
        result_lost |-> ready);

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(conv_done));

    p_ready_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(conv_start) && !$past(conv_done)));

    p_deselect_low_r6: assert property (@(posedge clk) disable iff (rst)
        $past(sel_n, 2) |-> !ser_data);

endmodule

bind adc_result_shifter adcsr_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .sel_n       (sel_n),
    .ser_data    (ser_data),
    .ready       (ready),
    .result_lost (result_lost)
);

// File: tb/adc_result_shifter_tb_top.sv
module adc_result_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_word = '0;
    logic        ser_clk = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_data;
    logic        ready;
    logic        result_lost;

    int checks = 0;
    int failures = 0;
    int quiet = 0;

    // Behavioural reference state.
    logic [11:0] hold_m = '0;
    int          falls_m = 0;
    bit          spent_m = 0;
    bit          ready_m = 0;

    always #5 clk = ~clk;

    adc_result_shifter dut_i (
        .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
        .conv_word(conv_word), .ser_clk(ser_clk), .sel_n(sel_n),
        .ser_data(ser_data), .ready(ready), .result_lost(result_lost)
    );

    function automatic logic exp_bit();
        int p;
        if (sel_n || spent_m) return 1'b0;
        p = (falls_m > 11) ? 0 : 11 - falls_m;
        return hold_m[p];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison of the pin once inputs have settled (R9 latency bound).
    always @(negedge clk) begin
        if (!rst) begin
            if (quiet >= 4) chk(ser_data == exp_bit(), "R2 pin vs model", ser_data, exp_bit());
            quiet++;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_sclk(input logic v);
        @(negedge clk); #1;
        if (!sel_n) begin
            if (ser_clk && !v && falls_m < 12) falls_m++;
            if (!ser_clk && v && falls_m == 12) spent_m = 1;
        end
        ser_clk = v; quiet = 0;
    endtask

    task automatic drive_sel(input logic v);
        @(negedge clk); #1;
        if (v) begin falls_m = 0; spent_m = 0; end
        sel_n = v; quiet = 0;
    endtask

    // One full serial period, checking the bit held before the capture edge.
    task automatic clock_bit(input string req);
        chk(ser_data == exp_bit(), req, ser_data, exp_bit());
        drive_sclk(1'b1); step(5);
        drive_sclk(1'b0); step(5);
    endtask

    task automatic conv(input logic [11:0] w, input bit with_start);
        bit blocked;
        @(negedge clk); #1;
        blocked = ser_clk && !sel_n;
        conv_done = 1'b1; conv_start = with_start; conv_word = w; quiet = 0;
        if (!blocked) begin hold_m = w; falls_m = 0; spent_m = 0; end
        ready_m = 1;
        @(negedge clk); #1;
        conv_done = 1'b0; conv_start = 1'b0;
        chk(ready == ready_m, "R7 ready after done", ready, ready_m);
        chk(result_lost == blocked, "R4 lost pulse", result_lost, blocked);
        @(negedge clk);
        chk(result_lost == 1'b0, "R4 lost single cycle", result_lost, 0);
    endtask

    task automatic start_only();
        @(negedge clk); #1;
        conv_start = 1'b1;
        @(negedge clk); #1;
        conv_start = 1'b0;
        ready_m = 0;
        chk(ready == ready_m, "R7 ready falls on start", ready, ready_m);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(5);
        @(negedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(ser_data == 1'b0, "R1 data after reset", ser_data, 0);
        chk(ready == 1'b0, "R1 ready after reset", ready, 0);
        chk(result_lost == 1'b0, "R1 lost after reset", result_lost, 0);

        // R1: cleared word reads as zeros.
        drive_sel(1'b0); step(5);
        for (int i = 0; i < 12; i++) clock_bit("R1 zero word");
        drive_sel(1'b1); step(5);

        // R3: load with select inactive.
        conv(12'hA5D, 1'b0);

        // R9: select fall latency, exact cycles (MSB of A5D is 1).
        @(negedge clk); #1; sel_n = 1'b0; quiet = 0;
        @(negedge clk);
        chk(ser_data == 1'b0, "R9 not after first edge", ser_data, 0);
        @(negedge clk);
        chk(ser_data == 1'b1, "R9 after second edge", ser_data, 1);
        step(4);

        // R2 order, R5 tail and extra clocks.
        for (int i = 0; i < 12; i++) clock_bit("R2 msb first");
        chk(ser_data == 1'b1, "R5 lsb held until 13th rise", ser_data, 1);
        drive_sclk(1'b1); step(5);
        chk(ser_data == 1'b0, "R5 low after 13th rise", ser_data, 0);
        for (int i = 0; i < 3; i++) clock_bit("R5 stays low");

        // R6: deselect and reread.
        drive_sel(1'b1); step(5);
        chk(ser_data == 1'b0, "R6 low while deselected", ser_data, 0);
        drive_sel(1'b0); step(5);
        chk(ser_data == 1'b1, "R6 reread starts at msb", ser_data, 1);

        // R8: read during the next conversion.
        start_only();
        for (int i = 0; i < 4; i++) clock_bit("R8 read while converting");

        // R4: blocked load with clock high and selected.
        drive_sclk(1'b1); step(5);
        conv(12'h0F0, 1'b0);
        step(4);
        drive_sclk(1'b0); step(5);
        for (int i = 0; i < 3; i++) clock_bit("R4 old word kept");

        // R10 and R3: load mid-read with clock low while selected.
        conv(12'h3C6, 1'b0);
        step(4);
        chk(ser_data == 1'b0, "R10 restart at msb of new word", ser_data, 0);
        for (int i = 0; i < 12; i++) clock_bit("R10 new word order");

        // R7: simultaneous strobes keep ready high.
        start_only();
        conv(12'h801, 1'b1);
        chk(ready == 1'b1, "R7 done wins over start", ready, 1);

        // R3: clock high but deselected still loads.
        drive_sel(1'b1); step(2);
        drive_sclk(1'b1); step(5);
        conv(12'h6B3, 1'b0);
        drive_sclk(1'b0); step(5);
        drive_sel(1'b0); step(5);
        for (int i = 0; i < 12; i++) clock_bit("R3 load while deselected");
        drive_sel(1'b1); step(6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule